// File: doc/BRIEF.md
# Combinational Execute Unit: ALU, One-Bit Shifter and Magnitude Comparator

This block is the arithmetic core of a small 16-bit datapath. It takes two words, an operand-register word A and a bus word B. A 4-bit operation code selects a logic or arithmetic function, and the function's result then goes through a shift stage. That stage either forwards the word or moves it by one position, as a logical shift or as a rotation. The whole path is combinational, so the result settles in the same cycle the operands arrive and can be latched into an output register by the surrounding control.

Beside the result path sits an unsigned magnitude comparator. A 3-bit relation selector picks one of six relations between A and B, and the comparator returns a single condition bit for use by branch decisions. The condition bit depends only on A, B and the relation selector, so a compare can share a cycle with any ALU operation.

Top module: `exu_top`

## Requirements
- R1: Logic codes: 0000 gives B, 0001 gives A AND B, 0010 gives A OR B, 0011 gives NOT B, 0100 gives A XOR B.
- R2: Arithmetic codes, all modulo 2^16: 0101 gives A+B, 0110 gives A-B, 0111 gives B+1, 1000 gives B-1.
- R3: Code 1001 gives an all-zero word.
- R4: The unused codes 1010 to 1111 give B unchanged.
- R5: Shift mode 000 passes the ALU word to result_o unchanged, and the unused modes 101, 110 and 111 do the same.
- R6: Mode 001 shifts the ALU word left by one and mode 010 shifts it right by one, and each fills the vacated bit with 0.
- R7: Mode 011 rotates the ALU word left by one (bit 15 moves to bit 0) and mode 100 rotates it right by one (bit 0 moves to bit 15).
- R8: cond_o is 1 exactly when the unsigned relation A rel B holds, with rel 000 equal, 001 not equal, 010 greater, 011 greater-or-equal, 100 less, 101 less-or-equal; rel 110 and 111 give 0.
- R9: cond_o does not depend on the operation code or the shift mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 16 | Operand A, the held register word |
| opb_i | input | 16 | Operand B, the bus word |
| alu_op_i | input | 4 | ALU operation code |
| shf_mode_i | input | 3 | Shift-stage mode |
| rel_i | input | 3 | Comparator relation selector |
| result_o | output | 16 | ALU word after the shift stage |
| cond_o | output | 1 | Branch condition bit |

## Verification
The bound checker looks at every evaluation. It checks that the zero code clears the word in pass mode, that the vacated bit of each logical shift is 0, that pass modes leave the ALU word untouched and that rotations keep its bit count. It also checks equal and not-equal against the operands. The bench alone can show that each operation code yields the exact value, that each relation gives the right answer at the wrap boundaries (0, FFFF, equal operands), and that the condition bit stays still while the operation and mode are swept.

// File: rtl/exu_pkg.sv
package exu_pkg;

   typedef enum logic [3:0] {
      ALU_PASS = 4'b0000,
      ALU_AND  = 4'b0001,
      ALU_OR   = 4'b0010,
      ALU_NOT  = 4'b0011,
      ALU_XOR  = 4'b0100,
      ALU_ADD  = 4'b0101,
      ALU_SUB  = 4'b0110,
      ALU_INC  = 4'b0111,
      ALU_DEC  = 4'b1000,
      ALU_ZERO = 4'b1001
   } alu_op_e;

   typedef enum logic [2:0] {
      SHF_PASS = 3'b000,
      SHF_SHL  = 3'b001,
      SHF_SHR  = 3'b010,
      SHF_ROL  = 3'b011,
      SHF_ROR  = 3'b100
   } shf_mode_e;

   typedef enum logic [2:0] {
      REL_EQ = 3'b000,
      REL_NE = 3'b001,
      REL_GT = 3'b010,
      REL_GE = 3'b011,
      REL_LT = 3'b100,
      REL_LE = 3'b101
   } rel_e;

   localparam int OP_W   = 4;
   localparam int MODE_W = 3;
   localparam int REL_W  = 3;

endpackage

// File: rtl/exu_alu.sv
module exu_alu
   import exu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [WIDTH-1:0] res_o
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   if (WIDTH < 2) begin : g_bad_width
      $error("exu_alu: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] sum_w;
   logic [WIDTH-1:0] addend_w;
   logic [WIDTH-1:0] base_w;
   logic             inv_w;
   logic             cin_w;

   // one shared adder serves add, subtract, increment and decrement
   always_comb begin
      base_w = opa_i;
      addend_w = opb_i;
      inv_w  = 1'b0;
      cin_w  = 1'b0;
      unique case (op_i)
         ALU_SUB: begin inv_w = 1'b1; cin_w = 1'b1; end
         ALU_INC: begin base_w = opb_i; addend_w = ONE; end
         ALU_DEC: begin base_w = opb_i; addend_w = ONE; inv_w = 1'b1; cin_w = 1'b1; end
         default: ;
      endcase
      sum_w = base_w + (inv_w ? ~addend_w : addend_w) + WIDTH'(cin_w);
   end

   always_comb begin
      case (op_i)
         ALU_PASS: res_o = opb_i;
         ALU_AND:  res_o = opa_i & opb_i;
         ALU_OR:   res_o = opa_i | opb_i;
         ALU_NOT:  res_o = ~opb_i;
         ALU_XOR:  res_o = opa_i ^ opb_i;
         ALU_ADD,
         ALU_SUB,
         ALU_INC,
         ALU_DEC:  res_o = sum_w;
         ALU_ZERO: res_o = '0;
         default:  res_o = opb_i;
      endcase
   end

endmodule

// File: rtl/exu_shift.sv
module exu_shift
   import exu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]  din_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [WIDTH-1:0]  dout_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("exu_shift: WIDTH must be at least 2");
   end

   logic is_shl, is_shr, is_rol, is_ror;
   logic left_fill, right_fill;

   assign is_shl = (mode_i == SHF_SHL);
   assign is_shr = (mode_i == SHF_SHR);
   assign is_rol = (mode_i == SHF_ROL);
   assign is_ror = (mode_i == SHF_ROR);

   // bit entering at the bottom on a left move, at the top on a right move
   assign left_fill  = is_rol ? din_i[MSB] : 1'b0;
   assign right_fill = is_ror ? din_i[0]   : 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_low, from_high;
      if (i == 0) begin : g_low_edge
         assign from_low = left_fill;
      end else begin : g_low_mid
         assign from_low = din_i[i-1];
      end
      if (i == MSB) begin : g_high_edge
         assign from_high = right_fill;
      end else begin : g_high_mid
         assign from_high = din_i[i+1];
      end
      always_comb begin
         if (is_shl || is_rol)      dout_o[i] = from_low;
         else if (is_shr || is_ror) dout_o[i] = from_high;
         else                       dout_o[i] = din_i[i];
      end
   end

endmodule

// File: rtl/exu_cmp.sv
module exu_cmp
   import exu_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter int CMP_STYLE = 0   // 0: direct relational operators, 1: borrow of a subtraction
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [REL_W-1:0] rel_i,
   output logic             cond_o
);
   if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_style
      $error("exu_cmp: CMP_STYLE must be 0 or 1");
   end

   logic eq_w, lt_w, gt_w;

   assign eq_w = (opa_i == opb_i);

   if (CMP_STYLE == 0) begin : g_direct
      assign lt_w = (opa_i < opb_i);
      assign gt_w = (opa_i > opb_i);
   end else begin : g_borrow
      logic [WIDTH:0] diff_w;
      assign diff_w = {1'b0, opa_i} - {1'b0, opb_i};
      assign lt_w   = diff_w[WIDTH];
      assign gt_w   = ~diff_w[WIDTH] & ~eq_w;
   end

   always_comb begin
      case (rel_i)
         REL_EQ:  cond_o = eq_w;
         REL_NE:  cond_o = ~eq_w;
         REL_GT:  cond_o = gt_w;
         REL_GE:  cond_o = gt_w | eq_w;
         REL_LT:  cond_o = lt_w;
         REL_LE:  cond_o = lt_w | eq_w;
         default: cond_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/exu_top.sv
module exu_top
   import exu_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter int CMP_STYLE = 0
) (
   input  logic [WIDTH-1:0]  opa_i,
   input  logic [WIDTH-1:0]  opb_i,
   input  logic [OP_W-1:0]   alu_op_i,
   input  logic [MODE_W-1:0] shf_mode_i,
   input  logic [REL_W-1:0]  rel_i,
   output logic [WIDTH-1:0]  result_o,
   output logic              cond_o
);
   logic [WIDTH-1:0] alu_res;

   exu_alu #(.WIDTH(WIDTH)) u_alu (
      .opa_i (opa_i),
      .opb_i (opb_i),
      .op_i  (alu_op_i),
      .res_o (alu_res)
   );

   exu_shift #(.WIDTH(WIDTH)) u_shift (
      .din_i  (alu_res),
      .mode_i (shf_mode_i),
      .dout_o (result_o)
   );

   exu_cmp #(.WIDTH(WIDTH), .CMP_STYLE(CMP_STYLE)) u_cmp (
      .opa_i  (opa_i),
      .opb_i  (opb_i),
      .rel_i  (rel_i),
      .cond_o (cond_o)
   );

endmodule

// File: rtl/exu_top_chk.sv
module exu_top_chk
   import exu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0]  opa_i,
   input logic [WIDTH-1:0]  opb_i,
   input logic [OP_W-1:0]   alu_op_i,
   input logic [MODE_W-1:0] shf_mode_i,
   input logic [REL_W-1:0]  rel_i,
   input logic [WIDTH-1:0]  result_o,
   input logic              cond_o,
   input logic [WIDTH-1:0]  alu_res
);
   logic pass_mode;
   assign pass_mode = (shf_mode_i == SHF_PASS) || (shf_mode_i > SHF_ROR);

   always_comb begin
      if (alu_op_i == ALU_ZERO && pass_mode)
         p_zero_word_r3: assert (result_o == '0) else $error("zero code left bits set");
      if (pass_mode)
         p_pass_mode_r5: assert (result_o == alu_res) else $error("pass mode altered word");
      if (shf_mode_i == SHF_SHL)
         p_shl_fill_r6: assert (result_o[0] == 1'b0) else $error("left shift fill not 0");
      if (shf_mode_i == SHF_SHR)
         p_shr_fill_r6: assert (result_o[WIDTH-1] == 1'b0) else $error("right shift fill not 0");
      if (shf_mode_i == SHF_ROL || shf_mode_i == SHF_ROR)
         p_rot_ones_r7: assert ($countones(result_o) == $countones(alu_res))
            else $error("rotation lost or gained bits");
      if (rel_i == REL_EQ)
         p_eq_rel_r8: assert (cond_o == (opa_i == opb_i)) else $error("equal relation wrong");
      if (rel_i == REL_NE)
         p_ne_rel_r8: assert (cond_o == (opa_i != opb_i)) else $error("not-equal relation wrong");
   end

endmodule

bind exu_top exu_top_chk #(.WIDTH(WIDTH)) u_chk (
   .opa_i      (opa_i),
   .opb_i      (opb_i),
   .alu_op_i   (alu_op_i),
   .shf_mode_i (shf_mode_i),
   .rel_i      (rel_i),
   .result_o   (result_o),
   .cond_o     (cond_o),
   .alu_res    (alu_res)
);

// File: tb/exu_top_bench.sv
module exu_top_bench;
   localparam int W = 16;
   localparam time CLK_PERIOD = 10ns;
   localparam int WATCHDOG_CYCLES = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  a, b;
   logic [3:0]    op;
   logic [2:0]    mode, rel;
   logic [W-1:0]  res;
   logic          cnd;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   exu_top u_exu_top (
      .opa_i(a), .opb_i(b), .alu_op_i(op), .shf_mode_i(mode), .rel_i(rel),
      .result_o(res), .cond_o(cnd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [W-1:0] ref_alu(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
      case (o)
         4'd0: return y;
         4'd1: return x & y;
         4'd2: return x | y;
         4'd3: return ~y;
         4'd4: return x ^ y;
         4'd5: return W'(x + y);
         4'd6: return W'(x - y);
         4'd7: return W'(y + 1);
         4'd8: return W'(y - 1);
         4'd9: return '0;
         default: return y;
      endcase
   endfunction

   function automatic logic [W-1:0] ref_shift(logic [2:0] m, logic [W-1:0] x);
      case (m)
         3'd1: return {x[W-2:0], 1'b0};
         3'd2: return {1'b0, x[W-1:1]};
         3'd3: return {x[W-2:0], x[W-1]};
         3'd4: return {x[0], x[W-1:1]};
         default: return x;
      endcase
   endfunction

   function automatic logic ref_cmp(logic [2:0] r, logic [W-1:0] x, logic [W-1:0] y);
      case (r)
         3'd0: return x == y;
         3'd1: return x != y;
         3'd2: return x > y;
         3'd3: return x >= y;
         3'd4: return x < y;
         3'd5: return x <= y;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] o, logic [2:0] m);
      if (m == 3'd1 || m == 3'd2) return "R6";
      if (m == 3'd3 || m == 3'd4) return "R7";
      if (m > 3'd4) return "R5";
      if (o <= 4'd4) return "R1";
      if (o <= 4'd8) return "R2";
      if (o == 4'd9) return "R3";
      return "R4";
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h (a=%h b=%h op=%b mode=%b rel=%b)",
                  req, act, exp, a, b, op, mode, rel);
      end
   endtask

   task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] o,
                        logic [2:0] m, logic [2:0] r);
      @(negedge clk);
      a = x; b = y; op = o; mode = m; rel = r;
      #1;
      check(tag_of(o, m), res, ref_shift(m, ref_alu(o, x, y)));
      check("R8", W'(cnd), W'(ref_cmp(r, x, y)));
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; op = '0; mode = '0; rel = '0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      void'($urandom(32'd20240611));

      // quiescent state: zero operands, pass code, equal relation
      #1;
      check("R1", res, 16'h0000);
      check("R8", W'(cnd), W'(1'b1));

      // R2 wrap corners
      apply(16'hFFFF, 16'h0001, 4'd5, 3'd0, 3'd2);
      apply(16'h0000, 16'h0001, 4'd6, 3'd0, 3'd4);
      apply(16'h1234, 16'hFFFF, 4'd7, 3'd0, 3'd3);
      apply(16'h1234, 16'h0000, 4'd8, 3'd0, 3'd5);
      // R3 zero under every shift mode
      for (int m = 0; m < 8; m++) apply(16'hFFFF, 16'hFFFF, 4'd9, 3'(m), 3'd0);
      // R4 unused codes give B
      for (int o = 10; o < 16; o++) apply(16'hA5A5, 16'h5A3C, 4'(o), 3'd0, 3'd1);
      // R6 / R7 edge bits
      apply(16'h0000, 16'h8001, 4'd0, 3'd1, 3'd0);
      apply(16'h0000, 16'h8001, 4'd0, 3'd2, 3'd0);
      apply(16'h0000, 16'h8001, 4'd0, 3'd3, 3'd0);
      apply(16'h0000, 16'h8001, 4'd0, 3'd4, 3'd0);
      // R8 every relation on less, equal, greater and extreme pairs
      for (int r = 0; r < 8; r++) begin
         apply(16'h0000, 16'hFFFF, 4'd0, 3'd0, 3'(r));
         apply(16'h7FFF, 16'h7FFF, 4'd0, 3'd0, 3'(r));
         apply(16'hFFFF, 16'h0000, 4'd0, 3'd0, 3'(r));
         apply(16'h8000, 16'h7FFF, 4'd0, 3'd0, 3'(r));
      end
      // R9 condition steady while op and mode sweep
      for (int o = 0; o < 16; o++)
         for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            a = 16'h0040; b = 16'h0041; op = 4'(o); mode = 3'(m); rel = 3'd4;
            #1;
            check("R9", W'(cnd), W'(1'b1));
         end
      // constrained random across all codes, modes and relations
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] x, y;
         x = W'($urandom);
         y = (i % 5 == 0) ? x : W'($urandom);
         apply(x, y, 4'($urandom_range(15)), 3'($urandom_range(7)), 3'($urandom_range(7)));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule